// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

This block is a small multi-cycle processor core built around a single accumulator. It runs a program of one-address instructions held in a synchronous, word-addressed memory. Each memory access goes through a dedicated effective-address register, which drives the memory address, and a memory buffer register, which receives read data and supplies write data. A program counter tracks the next instruction, and an instruction register holds the one being executed.

Each instruction passes through a fixed chain of states, and each state performs one register transfer. First the instruction is fetched: the address is loaded, the memory is read, and the word is captured. It is then decoded and the counter is stepped. Next the operand address is loaded from the instruction. Finally the operand is read, the instruction executes, or the accumulator is written back to memory. The core stops at a halt instruction and stays stopped until reset.

Top module: `acc_seq_core`

## Requirements
- R1: Synchronous active-high reset clears the program counter, the accumulator and the sequencer. After reset the halt output and the write strobe are low, and the first instruction is fetched from address 0.
- R2: An instruction word is 16 bits. Bits 15:12 hold the opcode and bits 11:0 hold the operand address. The opcode values are 0 for halt, 1 for load, 2 for add and 3 for store.
- R3: The program counter advances by exactly one per instruction, so instructions run from consecutive addresses.
- R4: Load (opcode 1) sets the accumulator to the word at the operand address.
- R5: Add (opcode 2) sets the accumulator to the accumulator plus the word at the operand address, modulo 2^16.
- R6: Store (opcode 3) writes the accumulator to the operand address. The write strobe is high for exactly one cycle, with the operand address on the address output.
- R7: Each instruction takes a fixed number of cycles: 9 for load and add, 8 for store, and 5 for an unused opcode. With a store at address 0, the write strobe is high in the 8th cycle after reset is released.
- R8: Halt (opcode 0) raises the halt output in the cycle after its 5-cycle fetch. The halt output then stays high with no further writes and a steady address until reset. Words after the halt are never executed.
- R9: Opcodes 4 to 15 have no effect: the accumulator and memory are untouched, and execution continues at the next address.
- R10: A reset applied while halted restarts execution from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 12 | Memory word address, driven by the effective-address register |
| memWdata | output | 16 | Write data, driven by the memory buffer register |
| memWe | output | 1 | Write strobe, one cycle per store |
| memRdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The accumulator has no port of its own, so its value can only be seen through a later store. Every arithmetic case is therefore a short program that ends in a store and a halt, and the stored word is then compared with the expected sum or load. The fixed cycle counts cannot be seen directly either. They are measured as the number of clock edges from reset release to the write strobe or to the halt output, for programs whose expected totals differ only by the instruction under test.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  parameter int DATA_W = 16;
  parameter int ADDR_W = 12;
  parameter int OPC_W  = DATA_W - ADDR_W;

  typedef enum logic [OPC_W-1:0] {
    OP_HALT  = 'd0,
    OP_LOAD  = 'd1,
    OP_ADD   = 'd2,
    OP_STORE = 'd3
  } opcode_t;

  typedef enum logic [3:0] {
    ST_FETCH_ADDR,
    ST_FETCH_READ,
    ST_FETCH_CAP,
    ST_DECODE,
    ST_PC_STEP,
    ST_OPND_ADDR,
    ST_OPND_READ,
    ST_OPND_CAP,
    ST_EXECUTE,
    ST_STORE_PREP,
    ST_STORE_WRITE,
    ST_HALTED
  } seqState_t;

  typedef struct packed {
    logic earFromPc;
    logic earFromIr;
    logic mbrFromMem;
    logic mbrFromAcc;
    logic irFromMbr;
    logic pcStep;
    logic accLoad;
    logic accAdd;
    logic memWrite;
  } seqStrobes_t;
endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OPC_W-1:0]     opcode,
  output seqStrobes_t          strobes,
  output logic                 halted
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH_ADDR;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_FETCH_ADDR: begin
        strobes.earFromPc = 1'b1;
        nextState = ST_FETCH_READ;
      end
      ST_FETCH_READ: nextState = ST_FETCH_CAP;
      ST_FETCH_CAP: begin
        strobes.mbrFromMem = 1'b1;
        nextState = ST_DECODE;
      end
      ST_DECODE: begin
        strobes.irFromMbr = 1'b1;
        nextState = ST_PC_STEP;
      end
      ST_PC_STEP: begin
        strobes.pcStep = 1'b1;
        case (opcode)
          OP_HALT:                   nextState = ST_HALTED;
          OP_LOAD, OP_ADD, OP_STORE: nextState = ST_OPND_ADDR;
          default:                   nextState = ST_FETCH_ADDR;
        endcase
      end
      ST_OPND_ADDR: begin
        strobes.earFromIr = 1'b1;
        nextState = (opcode == OP_STORE) ? ST_STORE_PREP : ST_OPND_READ;
      end
      ST_OPND_READ: nextState = ST_OPND_CAP;
      ST_OPND_CAP: begin
        strobes.mbrFromMem = 1'b1;
        nextState = ST_EXECUTE;
      end
      ST_EXECUTE: begin
        strobes.accLoad = (opcode == OP_LOAD);
        strobes.accAdd  = (opcode == OP_ADD);
        nextState = ST_FETCH_ADDR;
      end
      ST_STORE_PREP: begin
        strobes.mbrFromAcc = 1'b1;
        nextState = ST_STORE_WRITE;
      end
      ST_STORE_WRITE: begin
        strobes.memWrite = 1'b1;
        nextState = ST_FETCH_ADDR;
      end
      ST_HALTED: nextState = ST_HALTED;
      default:   nextState = ST_FETCH_ADDR;
    endcase
  end

  assign halted = (state == ST_HALTED);
endmodule

// File: rtl/acc_seq_datapath.sv
module acc_seq_datapath
  import acc_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  seqStrobes_t        strobes,
  input  logic [DATA_W-1:0]  memRdata,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  output logic [OPC_W-1:0]   opcode,
  output logic [ADDR_W-1:0]  pcVal
);
  localparam int OPC_LSB = ADDR_W;

  logic [ADDR_W-1:0] pc, ear;
  logic [DATA_W-1:0] ir, mbr, acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ear <= '0;
      ir  <= '0;
      mbr <= '0;
      acc <= '0;
    end else begin
      if (strobes.earFromPc)       ear <= pc;
      else if (strobes.earFromIr)  ear <= ir[ADDR_W-1:0];
      if (strobes.mbrFromMem)      mbr <= memRdata;
      else if (strobes.mbrFromAcc) mbr <= acc;
      if (strobes.irFromMbr)       ir  <= mbr;
      if (strobes.pcStep)          pc  <= pc + 1'b1;
      if (strobes.accLoad)         acc <= mbr;
      else if (strobes.accAdd)     acc <= acc + mbr;
    end
  end

  assign memAddr  = ear;
  assign memWdata = mbr;
  assign opcode   = ir[OPC_LSB +: OPC_W];
  assign pcVal    = pc;
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  output logic               memWe,
  input  logic [DATA_W-1:0]  memRdata,
  output logic               halted
);
  seqStrobes_t       strobes;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] pcVal;

  acc_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .strobes (strobes),
    .halted  (halted)
  );

  acc_seq_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode),
    .pcVal    (pcVal)
  );

  assign memWe = strobes.memWrite;
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
  import acc_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              memWe,
  input logic              halted,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] pcVal
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!halted && !memWe && pcVal == '0));

  // R3
  pc_single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pcVal) |-> (pcVal == $past(pcVal) + 1'b1));

  // R6
  write_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |=> !memWe);

  // R6
  write_addr_settled_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> $stable(memAddr));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R8
  halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !memWe);

  // R8
  halt_addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(memAddr));
endmodule

bind acc_seq_core acc_seq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .memWe   (memWe),
  .halted  (halted),
  .memAddr (memAddr),
  .pcVal   (pcVal)
);

// File: tb/acc_seq_core_test.sv
module acc_seq_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic        memWe;
  logic [15:0] memRdata;
  logic        halted;

  logic [15:0] mem [0:4095];

  int compared = 0;
  int mismatched = 0;

  int haltEdge, weCount, weFirst;
  logic [11:0] weAddr;

  always #2.5 clk = ~clk;

  acc_seq_core uut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  // Resets the core, then counts edges up to the halt output.
  task automatic runProg(input int maxEdges);
    haltEdge = -1; weCount = 0; weFirst = -1; weAddr = '0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    for (int n = 1; n <= maxEdges; n++) begin
      @(posedge clk); #1;
      if (memWe) begin
        weCount++;
        if (weFirst < 0) begin weFirst = n; weAddr = memAddr; end
      end
      if (halted && haltEdge < 0) haltEdge = n;
      if (haltEdge >= 0 && n >= haltEdge + 20) break;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 halted in reset", halted, 0);
    check("R1 strobe in reset", memWe, 0);
  endtask

  task automatic t_loadAdd();
    clearMem();
    mem[0] = ins(4'd1, 12'd100);
    mem[1] = ins(4'd2, 12'd101);
    mem[2] = ins(4'd3, 12'd102);
    mem[3] = ins(4'd0, 12'd0);
    mem[100] = 16'h1234; mem[101] = 16'h0101;
    runProg(200);
    check("R4 R5 load add store", mem[102], 16'h1335);
    check("R3 R7 halt edge after load add store", haltEdge, 9 + 9 + 8 + 5);
  endtask

  task automatic t_wrap();
    clearMem();
    mem[0] = ins(4'd1, 12'hFF0);
    mem[1] = ins(4'd2, 12'hFF1);
    mem[2] = ins(4'd3, 12'hFF2);
    mem[3] = ins(4'd0, 12'd0);
    mem[12'hFF0] = 16'hFFFF; mem[12'hFF1] = 16'h0002;
    runProg(200);
    check("R5 add wraps", mem[12'hFF2], 16'h0001);
  endtask

  task automatic t_staTiming();
    clearMem();
    mem[0] = ins(4'd3, 12'd50);
    mem[1] = ins(4'd0, 12'd0);
    mem[50] = 16'hBEEF;
    runProg(100);
    check("R1 accumulator cleared", mem[50], 16'h0000);
    check("R6 single strobe", weCount, 1);
    check("R7 strobe edge", weFirst, 7);
    check("R6 write address", weAddr, 12'd50);
    check("R8 halt edge after store", haltEdge, 13);
  endtask

  task automatic t_loadTiming();
    clearMem();
    mem[0] = ins(4'd1, 12'd10);
    mem[1] = ins(4'd0, 12'd0);
    runProg(100);
    check("R7 load cycle count", haltEdge, 14);
  endtask

  task automatic t_nop();
    clearMem();
    mem[0] = ins(4'd1, 12'd200);
    mem[1] = ins(4'hF, 12'd201);
    mem[2] = ins(4'd7, 12'd202);
    mem[3] = ins(4'd3, 12'd203);
    mem[4] = ins(4'd0, 12'd0);
    mem[200] = 16'h5A5A; mem[201] = 16'h1111; mem[202] = 16'h2222;
    runProg(200);
    check("R9 acc kept over unused opcodes", mem[203], 16'h5A5A);
    check("R9 operand word untouched", mem[201], 16'h1111);
    check("R9 only one write", weCount, 1);
    check("R2 R9 total cycles", haltEdge, 9 + 5 + 5 + 8 + 5);
  endtask

  task automatic t_halt();
    clearMem();
    mem[0] = ins(4'd0, 12'd0);
    mem[1] = ins(4'd3, 12'd300);
    mem[300] = 16'h7777;
    runProg(100);
    check("R8 halt edge", haltEdge, 5);
    check("R8 no write after halt", weCount, 0);
    check("R8 still halted", halted, 1);
    check("R8 next word not run", mem[300], 16'h7777);
  endtask

  task automatic t_restart();
    // Core is halted from t_halt; change the program and reset.
    mem[0] = ins(4'd1, 12'd400);
    mem[1] = ins(4'd3, 12'd401);
    mem[2] = ins(4'd0, 12'd0);
    mem[400] = 16'hC0DE;
    check("R10 halted before reset", halted, 1);
    runProg(200);
    check("R10 rerun from address 0", mem[401], 16'hC0DE);
    check("R10 halt after rerun", haltEdge, 9 + 8 + 5);
  endtask

  initial begin
    t_reset();
    t_loadAdd();
    t_wrap();
    t_staTiming();
    t_loadTiming();
    t_nop();
    t_halt();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule